// File: doc/BRIEF.md
# Fully Associative Page Translation Cache with Global Entries

This block caches virtual-to-physical page mappings for a 32-bit address space split into 4 KiB pages. A lookup presents a virtual address and receives the physical address, a hit flag and a miss flag in the same cycle. Only the upper 20 bits, the virtual page number, are translated. The low 12 bits pass through as they are. A refill port installs one mapping per cycle, supplied directly by whatever walks the page tables. Each mapping carries a global flag.

Two invalidation commands keep the cache consistent with software. An address-space switch drops every mapping that belongs to the old space. Mappings marked global survive this switch, but only while the global-page feature input is set. A single-page invalidate drops the one mapping whose page number matches, whether or not it is global. When translation is turned off, the block returns the virtual address unchanged and reports neither a hit nor a miss.

The block holds eight entries. A refill goes into the lowest-numbered free entry. When no entry is free, it goes into the entry named by a round-robin pointer. When a command and a refill arrive in the same cycle, the command acts on the table first and the refill then sees the result.

Top module: `pagemap_tlb`

## Requirements
- R1: The low 12 bits of `pa_o` always equal the low 12 bits of `va_i`. On a hit, bits 31:12 of `pa_o` carry the frame number of the matching entry.
- R2: While `xlat_en_i` is low, `pa_o` equals `va_i`, and `hit_o` and `miss_o` are both low.
- R3: While `xlat_en_i` is high, the lookup is combinational. `hit_o` is high when a valid entry's page number equals `va_i[31:12]`. `miss_o` is its inverse. On a miss, `pa_o` equals `va_i`.
- R4: With `glob_feat_i` high, a `flush_space_i` pulse invalidates every entry except those whose global bit is set.
- R5: With `glob_feat_i` low, a `flush_space_i` pulse invalidates every entry, global ones included.
- R6: An `inval_page_i` pulse invalidates only the entry whose page number equals `inval_vpn_i`, even if that entry is global. Other entries keep translating.
- R7: A refill whose page number matches no valid entry is written into the lowest-indexed invalid entry. The round-robin pointer does not move.
- R8: When every entry is valid, a refill overwrites the entry at the round-robin pointer. The pointer then advances by one and wraps from 7 back to 0. The pointer changes only on a refill.
- R9: A refill whose page number equals that of a valid entry overwrites that entry in place, with no duplicate. One later single-page invalidate of that page therefore leaves no hit.
- R10: When an invalidation command and a refill occur in the same cycle, the invalidation is applied first and the refill second, so the refilled mapping is present afterwards.
- R11: Reset clears every valid bit and sets the round-robin pointer to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| xlat_en_i | input | 1 | Translation enable; low means identity mapping |
| glob_feat_i | input | 1 | Global-page feature enable |
| va_i | input | 32 | Virtual address to translate |
| pa_o | output | 32 | Physical address |
| hit_o | output | 1 | Lookup found a valid mapping |
| miss_o | output | 1 | Lookup found no mapping while translation is on |
| fill_i | input | 1 | Install a mapping this cycle |
| fill_vpn_i | input | 20 | Virtual page number of the new mapping |
| fill_pfn_i | input | 20 | Physical frame number of the new mapping |
| fill_glob_i | input | 1 | Global flag of the new mapping |
| flush_space_i | input | 1 | Address-space switch: drop non-global mappings |
| inval_page_i | input | 1 | Drop the mapping for one page |
| inval_vpn_i | input | 20 | Page number targeted by `inval_page_i` |

## Verification
Some properties are checked on every cycle. These are the pass-through of the page offset, the identity mapping while translation is off, and the exclusive hit/miss pair with an unchanged address on a miss. The cycle after each space flush is also checked: each entry's survival has to agree with its global bit and with the feature enable. The round-robin pointer is checked to stay put on cycles without a refill. Only the bench scenarios can show the replacement order: lowest free slot first, then the rotating victim and its wrap. They also show in-place overwrite of a repeated page, single-page removal of a global entry, and the ordering of a command against a refill in the same cycle. Each of these is seen as a sequence of lookup hits and misses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VA_W    = 32;
    parameter int OFF_W   = 12;
    parameter int VPN_W   = VA_W - OFF_W;
    parameter int ENTRIES = 8;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic [VPN_W-1:0] vpn;
        logic [VPN_W-1:0] pfn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam.sv
// Associative compare of one key against every entry of the table.
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = ENTRIES
) (
    input  tlb_entry_t [N-1:0] tab_i,
    input  logic [VPN_W-1:0]   key_i,
    output logic [N-1:0]       match_o,
    output logic               any_o,
    output logic [VPN_W-1:0]   pfn_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = tab_i[g].valid && (tab_i[g].vpn == key_i);
    end

    assign any_o = |match_o;

    // At most one entry matches, so an OR of the gated frames selects it.
    always_comb begin
        pfn_o = '0;
        for (int i = 0; i < N; i++) begin
            if (match_o[i]) pfn_o = pfn_o | tab_i[i].pfn;
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Chooses the slot a refill writes: matching entry, else lowest free, else round robin.
module tlb_victim #(
    parameter int N     = 8,
    parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid_i,
    input  logic [N-1:0]     same_i,
    input  logic [PTR_W-1:0] rr_i,
    output logic [N-1:0]     sel_o,
    output logic             use_rr_o
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic             have_free;
    logic [PTR_W-1:0] free_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (!valid_i[i] && !have_free) begin
                have_free = 1'b1;
                free_idx  = PTR_W'(i);
            end
        end
    end

    always_comb begin
        use_rr_o = 1'b0;
        if (|same_i) begin
            sel_o = same_i;
        end else if (have_free) begin
            sel_o = ONE << free_idx;
        end else begin
            sel_o    = ONE << rr_i;
            use_rr_o = 1'b1;
        end
    end
endmodule

// File: rtl/pagemap_tlb.sv
module pagemap_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = ENTRIES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             xlat_en_i,
    input  logic             glob_feat_i,
    input  logic [VA_W-1:0]  va_i,
    output logic [VA_W-1:0]  pa_o,
    output logic             hit_o,
    output logic             miss_o,
    input  logic             fill_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [VPN_W-1:0] fill_pfn_i,
    input  logic             fill_glob_i,
    input  logic             flush_space_i,
    input  logic             inval_page_i,
    input  logic [VPN_W-1:0] inval_vpn_i
);
    localparam int PTR_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        tlb_entry_t [NUM_ENTRIES-1:0] tab;
        logic [PTR_W-1:0]             rr;
    } state_t;

    state_t st_d, st_q;

    // Lookup against the registered table.
    logic [NUM_ENTRIES-1:0] look_match;
    logic                   look_hit;
    logic [VPN_W-1:0]       look_pfn;

    tlb_cam #(.N(NUM_ENTRIES)) u_look_cam (
        .tab_i   (st_q.tab),
        .key_i   (va_i[VA_W-1:OFF_W]),
        .match_o (look_match),
        .any_o   (look_hit),
        .pfn_o   (look_pfn)
    );

    // Single-page invalidate compare against the registered table.
    logic [NUM_ENTRIES-1:0] inv_match;
    logic                   inv_any;
    logic [VPN_W-1:0]       inv_pfn;

    tlb_cam #(.N(NUM_ENTRIES)) u_inv_cam (
        .tab_i   (st_q.tab),
        .key_i   (inval_vpn_i),
        .match_o (inv_match),
        .any_o   (inv_any),
        .pfn_o   (inv_pfn)
    );

    // Table after this cycle's invalidations, before the refill.
    tlb_entry_t [NUM_ENTRIES-1:0] post_tab;
    logic [NUM_ENTRIES-1:0]       post_valid;

    always_comb begin
        post_tab = st_q.tab;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if ((flush_space_i && !(glob_feat_i && st_q.tab[i].glob)) ||
                (inval_page_i && inv_match[i])) begin
                post_tab[i].valid = 1'b0;
            end
            post_valid[i] = post_tab[i].valid;
        end
    end

    // Refill compare against the post-invalidate table.
    logic [NUM_ENTRIES-1:0] fill_same;
    logic                   fill_any;
    logic [VPN_W-1:0]       fill_old_pfn;

    tlb_cam #(.N(NUM_ENTRIES)) u_fill_cam (
        .tab_i   (post_tab),
        .key_i   (fill_vpn_i),
        .match_o (fill_same),
        .any_o   (fill_any),
        .pfn_o   (fill_old_pfn)
    );

    logic [NUM_ENTRIES-1:0] fill_sel;
    logic                   fill_use_rr;

    tlb_victim #(.N(NUM_ENTRIES), .PTR_W(PTR_W)) u_victim (
        .valid_i  (post_valid),
        .same_i   (fill_same),
        .rr_i     (st_q.rr),
        .sel_o    (fill_sel),
        .use_rr_o (fill_use_rr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.tab = post_tab;
        if (fill_i) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                if (fill_sel[i]) begin
                    st_d.tab[i].valid = 1'b1;
                    st_d.tab[i].glob  = fill_glob_i;
                    st_d.tab[i].vpn   = fill_vpn_i;
                    st_d.tab[i].pfn   = fill_pfn_i;
                end
            end
            if (fill_use_rr) begin
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs.
    always_comb begin
        hit_o  = xlat_en_i && look_hit;
        miss_o = xlat_en_i && !look_hit;
        pa_o   = hit_o ? {look_pfn, va_i[OFF_W-1:0]} : va_i;
    end

    // Per-entry views handed to the bound checker.
    logic [NUM_ENTRIES-1:0] vld_q, glb_q;
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_view
        assign vld_q[g] = st_q.tab[g].valid;
        assign glb_q[g] = st_q.tab[g].glob;
    end

    logic unused_ok;
    assign unused_ok = ^{inv_any, inv_pfn, fill_any, fill_old_pfn, look_match};
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
#(
    parameter int N     = ENTRIES,
    parameter int PTR_W = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             xlat_en_i,
    input logic             glob_feat_i,
    input logic             flush_space_i,
    input logic             inval_page_i,
    input logic             fill_i,
    input logic [VA_W-1:0]  va_i,
    input logic [VA_W-1:0]  pa_o,
    input logic             hit_o,
    input logic             miss_o,
    input logic [N-1:0]     vld_q,
    input logic [N-1:0]     glb_q,
    input logic [PTR_W-1:0] rr_q
);
    p_offset_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pa_o[OFF_W-1:0] == va_i[OFF_W-1:0]);

    p_bypass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xlat_en_i |-> (pa_o == va_i && !hit_o && !miss_o));

    p_hit_xor_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xlat_en_i |-> (hit_o != miss_o));

    p_miss_ident_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_o |-> (pa_o == va_i));

    for (genvar g = 0; g < N; g++) begin : g_ent
        p_keep_global_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flush_space_i && glob_feat_i && !inval_page_i && !fill_i)
            |=> (vld_q[g] == $past(vld_q[g] && glb_q[g])));
    end

    p_flush_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_space_i && !glob_feat_i && !fill_i) |=> (vld_q == '0));

    p_rr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fill_i |=> $stable(rr_q));
endmodule

bind pagemap_tlb tlb_chk #(.N(NUM_ENTRIES), .PTR_W(PTR_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .xlat_en_i     (xlat_en_i),
    .glob_feat_i   (glob_feat_i),
    .flush_space_i (flush_space_i),
    .inval_page_i  (inval_page_i),
    .fill_i        (fill_i),
    .va_i          (va_i),
    .pa_o          (pa_o),
    .hit_o         (hit_o),
    .miss_o        (miss_o),
    .vld_q         (vld_q),
    .glb_q         (glb_q),
    .rr_q          (st_q.rr)
);

// File: tb/test_pagemap_tlb.sv
module test_pagemap_tlb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] OFS = 12'hA5C;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        xlat_en_i = 1'b1;
    logic        glob_feat_i = 1'b0;
    logic [31:0] va_i = '0;
    logic [31:0] pa_o;
    logic        hit_o, miss_o;
    logic        fill_i = 1'b0;
    logic [19:0] fill_vpn_i = '0;
    logic [19:0] fill_pfn_i = '0;
    logic        fill_glob_i = 1'b0;
    logic        flush_space_i = 1'b0;
    logic        inval_page_i = 1'b0;
    logic [19:0] inval_vpn_i = '0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    pagemap_tlb i_pagemap_tlb (
        .clk_i, .rst_ni, .xlat_en_i, .glob_feat_i, .va_i, .pa_o, .hit_o, .miss_o,
        .fill_i, .fill_vpn_i, .fill_pfn_i, .fill_glob_i,
        .flush_space_i, .inval_page_i, .inval_vpn_i
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Combinational lookup; called between edges.
    task automatic look(input string req, input logic [19:0] vpn,
                        input bit exp_hit, input logic [19:0] exp_pfn);
        va_i = {vpn, OFS};
        #1;
        chk({req, " hit"}, {31'd0, hit_o}, {31'd0, exp_hit});
        chk({req, " miss"}, {31'd0, miss_o}, {31'd0, !exp_hit});
        if (exp_hit) chk({req, " pa"}, pa_o, {exp_pfn, OFS});
        else         chk({req, " pa"}, pa_o, {vpn, OFS});
    endtask

    // One command cycle, entered and left at a falling edge.
    task automatic step(input bit f, input logic [19:0] vpn, input logic [19:0] pfn,
                        input bit g, input bit fl, input bit inv, input logic [19:0] ivpn);
        fill_i = f; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_glob_i = g;
        flush_space_i = fl; inval_page_i = inv; inval_vpn_i = ivpn;
        @(negedge clk_i);
        fill_i = 1'b0; flush_space_i = 1'b0; inval_page_i = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input bit g);
        step(1'b1, vpn, pfn, g, 1'b0, 1'b0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 1'b0;
        xlat_en_i = 1'b1; glob_feat_i = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    task automatic t_reset();   // R11
        do_reset();
        fill(20'h00123, 20'h55555, 1'b1);
        look("R1", 20'h00123, 1'b1, 20'h55555);
        do_reset();
        look("R11 cleared", 20'h00123, 1'b0, '0);
    endtask

    task automatic t_bypass();  // R2, R3
        do_reset();
        fill(20'h0ABCD, 20'h12345, 1'b0);
        xlat_en_i = 1'b0;
        va_i = {20'h0ABCD, OFS};
        #1;
        chk("R2 pa", pa_o, {20'h0ABCD, OFS});
        chk("R2 hit/miss", {30'd0, hit_o, miss_o}, 32'd0);
        xlat_en_i = 1'b1;
        look("R3 hit", 20'h0ABCD, 1'b1, 20'h12345);
        look("R3 miss", 20'h0ABCE, 1'b0, '0);
    endtask

    task automatic t_global_flush();  // R4, R5
        do_reset();
        glob_feat_i = 1'b1;
        fill(20'h00A00, 20'h0F00A, 1'b1);
        fill(20'h00B00, 20'h0F00B, 1'b0);
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0);
        look("R4 global kept", 20'h00A00, 1'b1, 20'h0F00A);
        look("R4 local dropped", 20'h00B00, 1'b0, '0);
        glob_feat_i = 1'b0;
        fill(20'h00B00, 20'h0F00B, 1'b0);
        step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0, '0);
        look("R5 global dropped", 20'h00A00, 1'b0, '0);
        look("R5 local dropped", 20'h00B00, 1'b0, '0);
    endtask

    task automatic t_page_inval();  // R6
        do_reset();
        glob_feat_i = 1'b1;
        fill(20'h00C01, 20'h0C001, 1'b1);
        fill(20'h00C02, 20'h0C002, 1'b0);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 20'h00C01);
        look("R6 global removed", 20'h00C01, 1'b0, '0);
        look("R6 neighbour kept", 20'h00C02, 1'b1, 20'h0C002);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 20'h00FFF);
        look("R6 no match no effect", 20'h00C02, 1'b1, 20'h0C002);
    endtask

    task automatic t_replace();  // R7, R8, R11 (pointer starts at 0)
        do_reset();
        for (int i = 0; i < 8; i++) fill(20'h00010 + 20'(i), 20'h00100 + 20'(i), 1'b0);
        look("R7 all filled", 20'h00017, 1'b1, 20'h00107);
        fill(20'h00020, 20'h00200, 1'b0);   // slot 0, rr -> 1
        fill(20'h00021, 20'h00201, 1'b0);   // slot 1, rr -> 2
        look("R11 rr from zero", 20'h00010, 1'b0, '0);
        look("R8 second victim", 20'h00011, 1'b0, '0);
        look("R8 untouched", 20'h00012, 1'b1, 20'h00102);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 20'h00015);
        fill(20'h00030, 20'h00300, 1'b0);   // free slot 5, rr stays 2
        fill(20'h00031, 20'h00301, 1'b0);   // slot 2, rr -> 3
        look("R7 free slot used", 20'h00030, 1'b1, 20'h00300);
        look("R7 rr held", 20'h00012, 1'b0, '0);
        look("R7 slot3 kept", 20'h00013, 1'b1, 20'h00103);
        for (int i = 0; i < 6; i++) fill(20'h00040 + 20'(i), 20'h00400 + 20'(i), 1'b0);
        look("R8 wrap evicts slot0", 20'h00020, 1'b0, '0);
        look("R8 slot1 kept", 20'h00021, 1'b1, 20'h00201);
        look("R8 newest", 20'h00045, 1'b1, 20'h00405);
    endtask

    task automatic t_same_page();  // R9
        do_reset();
        fill(20'h00D00, 20'h0D001, 1'b0);
        fill(20'h00D00, 20'h0D002, 1'b0);
        look("R9 overwritten", 20'h00D00, 1'b1, 20'h0D002);
        step(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, 20'h00D00);
        look("R9 no duplicate", 20'h00D00, 1'b0, '0);
    endtask

    task automatic t_ordering();  // R10
        do_reset();
        fill(20'h00E00, 20'h0E001, 1'b0);
        step(1'b1, 20'h00E00, 20'h0E002, 1'b0, 1'b0, 1'b1, 20'h00E00);
        look("R10 inval then fill", 20'h00E00, 1'b1, 20'h0E002);
        fill(20'h00E10, 20'h0E010, 1'b0);
        step(1'b1, 20'h00E20, 20'h0E020, 1'b0, 1'b1, 1'b0, '0);
        look("R10 flush then fill", 20'h00E20, 1'b1, 20'h0E020);
        look("R10 flushed", 20'h00E10, 1'b0, '0);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_global_flush();
        t_page_inval();
        t_replace();
        t_same_page();
        t_ordering();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule